// File: doc/BRIEF.md
# Configurable Input Digital Filter

This block cleans up one asynchronous digital line, for example an external trigger, before timer control logic uses it. The raw line is first brought into the kernel clock domain. It is then sampled at a programmable rate. The filtered output changes level only after a programmable number of consecutive samples disagree with it. Short glitches and bursts of noise shorter than that run are absorbed.

A 4-bit filter code picks the sample rate and the required run length together. A 2-bit divider setting sets the sampling clock from the kernel clock. Every rate is made as a one-cycle enable from a free-running prescaler, so only the kernel clock is used. Writing a new code or a new divider setting restarts the prescaler and the run counter. The output keeps the level it had.

Top module: `trigInFilter`

## Requirements
- R1: After reset, `filtOut` is 0. The run counter is empty, so a first disagreeing run must reach its full length before the output changes.
- R2: Timing is counted from a negedge at which the input is changed to a level other than `filtOut`. If the configuration also changes at that negedge, the first posedge after it is edge 1. Let P be the sample period in kernel cycles. The output changes at edge N+2 when P = 1, and at edge P*N+1 when P > 1. The sampling clock period is 1, 2 or 4 kernel cycles for `divSel` 00, 01 and 10, and 4 for 11.
- R3: Code 0000 samples at the sampling clock with N = 1, so the output follows each sample. The divider setting sets P.
- R4: Codes 0001, 0010 and 0011 sample every kernel cycle (P = 1) whatever the divider setting, with N = 2, 4 and 8.
- R5: Codes 0100/0101 use the sampling clock divided by 2, codes 0110/0111 divided by 4, and codes 1000/1001 divided by 8. In each pair the first code has N = 6 and the second N = 8.
- R6: Codes 1010, 1011 and 1100 use the sampling clock divided by 16, and codes 1101, 1110 and 1111 divided by 32. Within each group N is 5, 6 and 8.
- R7: A sample equal to the current output empties the run counter. A run of fewer than N consecutive disagreeing samples leaves the output unchanged.
- R8: Rising and falling output transitions obey the same run length and latency.
- R9: Any change of `filtCode` or `divSel` empties the run counter and restarts the prescaler. The output keeps its level. A partial run made before the change does not count toward the new N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawIn | input | 1 | Asynchronous input line |
| filtCode | input | 4 | Sample rate and run length selection |
| divSel | input | 2 | Sampling clock divider from kernel clock |
| filtOut | output | 1 | Filtered level |

## Verification
The hardest case to reach from the ports is the prescaler phase. It runs freely and cannot be seen outside the block, so the latency of one input step depends on history. The stimulus controls the phase by changing the configuration at the same negedge as the input step. The restart this causes puts the prescaler at a known phase, and each exact latency is then measured. For the R9 case, a partial run is built under one code and the code is then switched. The measured latency shows whether the earlier samples were discarded.

// File: rtl/trigInFilterPkg.sv
package trigInFilterPkg;
  localparam int MaxRun     = 8;
  localparam int CntW       = $clog2(MaxRun + 1);
  localparam int MaxDtsLog  = 2;
  localparam int MaxPresLog = 5;
  localparam int PerW       = MaxDtsLog + MaxPresLog;
  localparam int CodeW      = 4;
  localparam int DivW       = 2;

  typedef struct packed {
    logic            sampleEn;
    logic            clearCnt;
    logic [CntW-1:0] needCnt;
  } strobeT;
endpackage

// File: rtl/trigInFilterCtrl.sv
module trigInFilterCtrl
  import trigInFilterPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CodeW-1:0] filtCode,
  input  logic [DivW-1:0]  divSel,
  output strobeT           strobe
);
  logic [CodeW+DivW-1:0] cfgReg;
  logic                  cfgChanged;
  logic [PerW-1:0]       preCnt;
  logic [PerW-1:0]       lastTick;
  logic                  kernRate;
  int                    presLog;
  int                    dtsLog;
  logic [CntW-1:0]       runLen;

  assign cfgChanged = ({filtCode, divSel} != cfgReg);

  always_comb begin
    kernRate = 1'b0;
    presLog  = 0;
    runLen   = CntW'(1);
    unique case (filtCode)
      4'd0:  begin presLog = 0; runLen = CntW'(1); end
      4'd1:  begin kernRate = 1'b1; runLen = CntW'(2); end
      4'd2:  begin kernRate = 1'b1; runLen = CntW'(4); end
      4'd3:  begin kernRate = 1'b1; runLen = CntW'(8); end
      4'd4:  begin presLog = 1; runLen = CntW'(6); end
      4'd5:  begin presLog = 1; runLen = CntW'(8); end
      4'd6:  begin presLog = 2; runLen = CntW'(6); end
      4'd7:  begin presLog = 2; runLen = CntW'(8); end
      4'd8:  begin presLog = 3; runLen = CntW'(6); end
      4'd9:  begin presLog = 3; runLen = CntW'(8); end
      4'd10: begin presLog = 4; runLen = CntW'(5); end
      4'd11: begin presLog = 4; runLen = CntW'(6); end
      4'd12: begin presLog = 4; runLen = CntW'(8); end
      4'd13: begin presLog = 5; runLen = CntW'(5); end
      4'd14: begin presLog = 5; runLen = CntW'(6); end
      default: begin presLog = 5; runLen = CntW'(8); end
    endcase
  end

  always_comb begin
    unique case (divSel)
      2'd0:    dtsLog = 0;
      2'd1:    dtsLog = 1;
      default: dtsLog = 2;
    endcase
  end

  always_comb begin
    if (kernRate) lastTick = '0;
    else          lastTick = PerW'((1 << (dtsLog + presLog)) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      preCnt <= '0;
    end else begin
      cfgReg <= {filtCode, divSel};
      if (cfgChanged || preCnt >= lastTick) preCnt <= '0;
      else                                  preCnt <= preCnt + 1'b1;
    end
  end

  assign strobe.sampleEn = (preCnt == lastTick) && !cfgChanged;
  assign strobe.clearCnt = cfgChanged;
  assign strobe.needCnt  = runLen;

  assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgChanged |-> preCnt <= lastTick);
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgChanged) |-> preCnt == '0);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sampleEn, strobe.clearCnt}));
  assert_kernel_rate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (kernRate && !cfgChanged) |-> strobe.sampleEn);
endmodule

// File: rtl/trigInFilterData.sv
module trigInFilterData
  import trigInFilterPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rawIn,
  input  strobeT strobe,
  output logic   filtOut
);
  logic [SyncStages-1:0] syncQ;
  logic [CntW-1:0]       runCnt;
  logic                  sampleBit;

  generate
    for (genvar i = 0; i < SyncStages; i++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= rawIn;
        else             syncQ[i] <= syncQ[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  assign sampleBit = syncQ[SyncStages-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      filtOut <= 1'b0;
    end else if (strobe.clearCnt) begin
      runCnt <= '0;
    end else if (strobe.sampleEn) begin
      if (sampleBit == filtOut) begin
        runCnt <= '0;
      end else if (runCnt == CntW'(strobe.needCnt - 1'b1)) begin
        runCnt  <= '0;
        filtOut <= ~filtOut;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assert_cnt_below_need_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearCnt |-> runCnt < strobe.needCnt);
  assert_out_on_sample_R7: assert property (@(posedge clk) disable iff (!rstN)
    (filtOut != $past(filtOut)) |-> $past(strobe.sampleEn));
  assert_keep_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clearCnt) |-> (filtOut == $past(filtOut)) && (runCnt == '0));
endmodule

// File: rtl/trigInFilter.sv
module trigInFilter
  import trigInFilterPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [CodeW-1:0] filtCode,
  input  logic [DivW-1:0]  divSel,
  output logic             filtOut
);
  strobeT strobe;

  trigInFilterCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .filtCode (filtCode),
    .divSel   (divSel),
    .strobe   (strobe)
  );

  trigInFilterData #(.SyncStages(2)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (rawIn),
    .strobe  (strobe),
    .filtOut (filtOut)
  );
endmodule

// File: tb/trigInFilter_tb.sv
module trigInFilter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b0;
  logic [3:0] filtCode = 4'd0;
  logic [1:0] divSel = 2'd0;
  logic       filtOut;
  int errors = 0;
  int checks = 0;

  trigInFilter u_dut (.clk(clk), .rstN(rstN), .rawIn(rawIn),
    .filtCode(filtCode), .divSel(divSel), .filtOut(filtOut));

  always #10 clk = ~clk;

  localparam int NV = 24;
  // {code, divSel, expected edge of the output change}
  localparam logic [17:0] VECS [NV] = '{
    {4'd0, 2'd0, 12'd3},   {4'd1, 2'd0, 12'd4},   {4'd2, 2'd0, 12'd6},
    {4'd3, 2'd0, 12'd10},  {4'd4, 2'd0, 12'd13},  {4'd5, 2'd0, 12'd17},
    {4'd6, 2'd0, 12'd25},  {4'd7, 2'd0, 12'd33},  {4'd8, 2'd0, 12'd49},
    {4'd9, 2'd0, 12'd65},  {4'd10, 2'd0, 12'd81}, {4'd11, 2'd0, 12'd97},
    {4'd12, 2'd0, 12'd129},{4'd13, 2'd0, 12'd161},{4'd14, 2'd0, 12'd193},
    {4'd15, 2'd0, 12'd257},{4'd0, 2'd1, 12'd3},   {4'd1, 2'd1, 12'd4},
    {4'd4, 2'd1, 12'd25},  {4'd0, 2'd2, 12'd5},   {4'd9, 2'd2, 12'd257},
    {4'd15, 2'd2, 12'd1025},{4'd5, 2'd3, 12'd65}, {4'd0, 2'd3, 12'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic park(input logic lvl);
    @(negedge clk);
    filtCode = 4'd0; divSel = 2'd0; rawIn = lvl;
    repeat (8) @(negedge clk);
  endtask

  // Counts edges from the current negedge until filtOut reaches target.
  task automatic measure(input logic target, input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (filtOut == target) break;
    end
    if (filtOut != target) k = limit + 1;
  endtask

  task automatic stepLat(input logic [3:0] c, input logic [1:0] d, input logic lvl,
                         input int exp, input string req);
    int k;
    filtCode = c; divSel = d; rawIn = lvl;
    measure(lvl, exp + 4, k);
    check(k == exp, req, k, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int k;
    bit held;
    repeat (3) @(negedge clk);
    check(filtOut == 1'b0, "R1 out during reset", filtOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(filtOut == 1'b0, "R1 out after reset", filtOut, 0);
    // R1: empty counter, code 0011 needs a full run of 8 -> edge 10
    filtCode = 4'd3; rawIn = 1'b1;
    measure(1'b1, 14, k);
    check(k == 10, "R1 first run length", k, 10);

    // R2 R3 R4 R5 R6: vector table walk
    for (int i = 0; i < NV; i++) begin
      park(1'b0);
      @(negedge clk);
      stepLat(VECS[i][17:14], VECS[i][13:12], 1'b1, int'(VECS[i][11:0]),
              $sformatf("R2 R3 R4 R5 R6 vec%0d", i));
    end

    // R8: falling transitions
    park(1'b1);
    stepLat(4'd2, 2'd0, 1'b0, 6, "R8 fall code2");
    park(1'b1);
    stepLat(4'd13, 2'd0, 1'b0, 161, "R8 fall code13");
    park(1'b1);
    stepLat(4'd5, 2'd1, 1'b0, 33, "R8 fall code5 div1");

    // R7: short runs rejected
    park(1'b0);
    filtCode = 4'd3;
    repeat (4) @(negedge clk);
    held = 1'b1;
    rawIn = 1'b1; repeat (7) @(negedge clk);
    rawIn = 1'b0;
    repeat (12) begin @(negedge clk); if (filtOut) held = 1'b0; end
    check(held, "R7 run of 7 rejected", filtOut, 0);
    rawIn = 1'b1; repeat (5) @(negedge clk);
    rawIn = 1'b0; @(negedge clk);
    rawIn = 1'b1; repeat (5) @(negedge clk);
    rawIn = 1'b0;
    repeat (12) begin @(negedge clk); if (filtOut) held = 1'b0; end
    check(held, "R7 broken run rejected", filtOut, 0);
    stepLat(4'd3, 2'd0, 1'b1, 10, "R7 full run accepted");

    // R9: partial run discarded on code change
    park(1'b0);
    filtCode = 4'd3; rawIn = 1'b1;
    repeat (5) @(negedge clk);
    check(filtOut == 1'b0, "R9 partial run", filtOut, 0);
    filtCode = 4'd2;
    measure(1'b1, 9, k);
    check(k == 5, "R9 counter cleared", k, 5);

    // R9: level kept across a config change
    rawIn = 1'b0; filtCode = 4'd3;
    repeat (6) @(negedge clk);
    filtCode = 4'd15; divSel = 2'd2;
    held = 1'b1;
    repeat (40) begin @(negedge clk); if (!filtOut) held = 1'b0; end
    check(held, "R9 level kept", filtOut, 1);

    // R9: divider change restarts prescaler
    park(1'b0);
    filtCode = 4'd6; divSel = 2'd0;
    repeat (9) @(negedge clk);
    stepLat(4'd6, 2'd1, 1'b1, 49, "R9 divider restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule